// File: doc/BRIEF.md
# Device response data scrubber

This block is the response stage of a device adapter on a TL-UL style request/response link. It holds one request at a time. When the A channel accepts a request, the block records whether the request is a read or a write and whether it failed. It then presents the response word on the D channel until the host takes it.

The block does not leave a finished response word on the bus. One cycle after the D handshake completes, the data field is overwritten with an all-ones scrub pattern, unless a new request was accepted in the same cycle. Writes and failed requests always return all ones.

The parameter `LATENCY` sets the timing of read data:
- With 0, the read word is sampled in the cycle the request is accepted and is held in a register.
- With 1, the read word arrives one cycle after acceptance and passes straight to the output. It is latched only if the host applies backpressure.

Top module: `resp_scrub`

## Requirements
- R1: After reset, `d_valid_o` and `d_error_o` are 0 and `d_data_o` is all zeros.
- R2: `a_ready_o` is 1 exactly when no response is pending or the pending response is being taken this cycle (`d_ready_i` high). A request is accepted when `a_valid_i` and `a_ready_o` are both high.
- R3: With `LATENCY`=0, an accepted read without error shows the `rd_data_i` value from the accept cycle on `d_data_o`, from the next cycle until the response is taken.
- R4: An accepted write, or a request with `up_err_i` or `int_err_i` high, responds with `d_data_o` all ones. Its `d_error_o` is the OR of the two error inputs sampled at accept.
- R5: In the cycle after a D handshake with no new request accepted, `d_data_o` is all ones and `d_valid_o` is 0. It stays all ones until the next request is accepted.
- R6: A request accepted in the same cycle as a D handshake takes priority over scrubbing. `d_valid_o` stays 1 and the new response is shown.
- R7: While `d_valid_o` is 1 and `d_ready_i` is 0, `d_valid_o` stays 1 in the next cycle. `d_data_o` and `d_error_o` also stay unchanged, except for the live first cycle of a `LATENCY`=1 read.
- R8: With `LATENCY`=1, an accepted read without error shows the live `rd_data_i` on `d_data_o` in the first response cycle. Later backpressured cycles keep showing the value `rd_data_i` had in that first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_valid_i | input | 1 | Request valid |
| a_ready_o | output | 1 | Request ready |
| a_write_i | input | 1 | Request is a write |
| up_err_i | input | 1 | Error reported by the register/memory port |
| int_err_i | input | 1 | Error detected inside the adapter |
| rd_data_i | input | DW | Read word from the register/memory port |
| d_valid_o | output | 1 | Response valid |
| d_ready_i | input | 1 | Host ready for response |
| d_data_o | output | DW | Response data field |
| d_error_o | output | 1 | Response error flag |

## Verification
The first group of corner cases covers the cycle in which a D handshake and a new acceptance coincide:
- A design that scrubs there would corrupt the new response.
- A design that never scrubs would leave the previous read word visible while idle.

A second group covers a `LATENCY`=1 read taken in its very first cycle, and a read held under long backpressure:
- A design that forgets to latch would follow the changing `rd_data_i`.
- A design that latches but never clears would keep exposing the word.

Writes and failures mixed among reads catch a design that returns read data instead of all ones.

// File: rtl/resp_scrub.sv
module resp_scrub #(
  parameter int DW      = 32,
  parameter int LATENCY = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_valid_i,
  output logic          a_ready_o,
  input  logic          a_write_i,
  input  logic          up_err_i,
  input  logic          int_err_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          d_valid_o,
  input  logic          d_ready_i,
  output logic [DW-1:0] d_data_o,
  output logic          d_error_o
);

  localparam logic [DW-1:0] SCRUB = {DW{1'b1}};

  logic          pend_q;
  logic          err_q;
  logic [DW-1:0] hold_q;
  logic          rd_live_q;
  logic          a_ack, d_ack, req_err;

  assign a_ready_o = ~pend_q | d_ready_i;
  assign a_ack     = a_valid_i & a_ready_o;
  assign d_ack     = pend_q & d_ready_i;
  assign req_err   = up_err_i | int_err_i;
  assign d_valid_o = pend_q;
  assign d_error_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (a_ack) begin
      pend_q <= 1'b1;
      err_q  <= req_err;
    end else if (d_ack) begin
      pend_q <= 1'b0;
    end
  end

  generate
    if (LATENCY == 0) begin : g_lat0
      assign rd_live_q = 1'b0;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     hold_q <= '0;
        else if (a_ack)  hold_q <= (a_write_i | req_err) ? SCRUB : rd_data_i;
        else if (d_ack)  hold_q <= SCRUB;
      end

      assign d_data_o = hold_q;
    end else begin : g_lat1
      logic wr_q, live_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          hold_q <= '0;
          wr_q   <= 1'b0;
          live_q <= 1'b0;
        end else if (a_ack) begin
          hold_q <= SCRUB;
          wr_q   <= a_write_i;
          live_q <= ~a_write_i;
        end else if (d_ack) begin
          hold_q <= SCRUB;
          wr_q   <= 1'b0;
          live_q <= 1'b0;
        end else if (live_q) begin
          hold_q <= rd_data_i;
          live_q <= 1'b0;
        end
      end

      assign rd_live_q = live_q;
      assign d_data_o  = (err_q | wr_q) ? SCRUB :
                         live_q         ? rd_data_i : hold_q;
    end
  endgenerate

  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_valid_o && !d_ready_i) |-> !a_ready_o) else $error("busy accept"); // R2

  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_valid_o && !d_ready_i) |=> d_valid_o) else $error("valid dropped"); // R7

  AST_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_valid_o && !d_ready_i && !rd_live_q) |=> ($stable(d_data_o) && $stable(d_error_o)))
    else $error("data moved"); // R7

  AST_SCRUB_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_valid_o && d_ready_i && !a_valid_i) |=> (d_data_o == SCRUB && !d_valid_o))
    else $error("no scrub"); // R5

  AST_ERR_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_valid_o && d_error_o) |-> d_data_o == SCRUB) else $error("err data"); // R4

  AST_WRITE_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_valid_i && a_ready_o && a_write_i) |=> d_data_o == SCRUB) else $error("wr data"); // R4

  AST_ACCEPT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_valid_o && d_ready_i && a_valid_i) |=> d_valid_o) else $error("accept lost"); // R6

endmodule

// File: tb/resp_scrub_tb.sv
module resp_scrub_tb;
  localparam int DW = 32;
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic a_valid = 0, a_write = 0, up_err = 0, int_err = 0, d_ready = 0;
  logic [DW-1:0] rd0 = '0, rd1 = '0;
  logic a_rdy0, a_rdy1, dv0, dv1, de0, de1;
  logic [DW-1:0] dd0, dd1;

  resp_scrub #(.DW(DW), .LATENCY(0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .a_valid_i(a_valid), .a_ready_o(a_rdy0),
    .a_write_i(a_write), .up_err_i(up_err), .int_err_i(int_err), .rd_data_i(rd0),
    .d_valid_o(dv0), .d_ready_i(d_ready), .d_data_o(dd0), .d_error_o(de0));

  resp_scrub #(.DW(DW), .LATENCY(1)) u_dut_l1 (
    .clk_i(clk), .rst_ni(rst_n), .a_valid_i(a_valid), .a_ready_o(a_rdy1),
    .a_write_i(a_write), .up_err_i(up_err), .int_err_i(int_err), .rd_data_i(rd1),
    .d_valid_o(dv1), .d_ready_i(d_ready), .d_data_o(dd1), .d_error_o(de1));

  int checks = 0, fails = 0;

  // reference state: m0 for latency 0, m1 for latency 1
  logic v0 = 0, e0 = 0;
  logic [DW-1:0] h0 = '0;
  logic v1 = 0, e1 = 0, w1 = 0, f1 = 0;
  logic [DW-1:0] h1 = '0;
  logic prev_dack0 = 0, prev_acc0 = 0;

  function automatic logic [DW-1:0] exp_l1(logic e, logic w, logic f,
                                           logic [DW-1:0] h, logic [DW-1:0] live);
    if (e || w) return ONES;
    if (f)      return live;
    return h;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic ready_exp;
    ready_exp = !v0 || d_ready;
    chk("R2 a_ready lat0", {31'd0, a_rdy0}, {31'd0, ready_exp});
    chk("R2 a_ready lat1", {31'd0, a_rdy1}, {31'd0, !v1 || d_ready});
    chk(v0 ? "R7 d_valid lat0" : "R5 d_valid lat0", {31'd0, dv0}, {31'd0, v0});
    chk("R7 d_valid lat1", {31'd0, dv1}, {31'd0, v1});
    if (v0) chk("R4 d_error lat0", {31'd0, de0}, {31'd0, e0});
    if (v1) chk("R4 d_error lat1", {31'd0, de1}, {31'd0, e1});
    chk(prev_dack0 && !prev_acc0 ? "R5 scrub lat0" :
        prev_acc0 && prev_dack0 ? "R6 accept priority lat0" : "R3 data lat0", dd0, h0);
    chk(f1 ? "R8 live lat1" : "R8 held lat1", dd1, exp_l1(e1, w1, f1, h1, rd1));
  endtask

  task automatic advance();
    logic acc0, acc1, dk0, dk1, err;
    err  = up_err | int_err;
    acc0 = a_valid && (!v0 || d_ready);
    acc1 = a_valid && (!v1 || d_ready);
    dk0  = v0 && d_ready;
    dk1  = v1 && d_ready;
    prev_dack0 = dk0; prev_acc0 = acc0;
    if (acc0) begin v0 = 1; e0 = err; h0 = (a_write || err) ? ONES : rd0; end
    else if (dk0) begin v0 = 0; h0 = ONES; end
    if (acc1) begin v1 = 1; e1 = err; w1 = a_write; f1 = !a_write; h1 = ONES; end
    else if (dk1) begin v1 = 0; w1 = 0; f1 = 0; h1 = ONES; end
    else if (f1) begin h1 = rd1; f1 = 0; end
  endtask

  task automatic cyc(logic av, logic wr, logic ue, logic ie, logic dr);
    @(negedge clk);
    a_valid = av; a_write = wr; up_err = ue; int_err = ie; d_ready = dr;
    rd0 = $urandom; rd1 = $urandom;
    #1;
    check_all();
    advance();
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk("R1 reset data lat0", dd0, '0);
    chk("R1 reset data lat1", dd1, '0);
    chk("R1 reset valid", {30'd0, dv0, dv1}, '0);
    chk("R1 reset error", {30'd0, de0, de1}, '0);
    rst_n = 1;
    // directed: read, long backpressure, take
    cyc(1, 0, 0, 0, 0);
    repeat (5) cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    repeat (2) cyc(0, 0, 0, 0, 0);
    // read taken in first response cycle (R8 scrub of live word)
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    repeat (2) cyc(0, 0, 0, 0, 0);
    // back-to-back accept at handshake (R6)
    cyc(1, 0, 0, 0, 1);
    cyc(1, 0, 0, 0, 1);
    cyc(1, 1, 0, 0, 1);
    cyc(1, 0, 1, 0, 1);
    cyc(1, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 1);
    repeat (2) cyc(0, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic av, wr, ue, ie, dr;
      av = ($urandom % 3) != 0;
      wr = ($urandom % 4) == 0;
      ue = ($urandom % 10) == 0;
      ie = ($urandom % 12) == 0;
      dr = ($urandom % 3) == 0;
      cyc(av, wr, ue, ie, dr);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule